// File: doc/BRIEF.md
# Integer ALU with overflow trap

This block is the single-cycle arithmetic and logic unit of a 32-bit load-store RISC datapath. It is purely combinational. Each evaluation it receives an operation code, two register operands, a 16-bit instruction immediate and a 5-bit instruction shift field. It returns a 32-bit result, an overflow-trap flag and a write enable for the destination register.

The unit covers add and subtract, each in a trapping and a non-trapping form, including the immediate forms. It also covers bitwise AND, OR, XOR and NOR, left and right shifts by a constant or a register amount, signed and unsigned set-less-than, and load-upper-immediate. The unit extends the immediate itself. Arithmetic and compare forms sign-extend it, and logical forms zero-extend it. When a trapping form overflows, the flag rises and the write enable falls, so the exception logic upstream can take over and the destination register keeps its old value.

Top module: `alu_core`

## Requirements
- R1: Trapping forms ADD (code 0), SUB (code 2) and ADDI (code 4) assert ovf_trap exactly when the true signed result of the operation lies outside the 32-bit two's-complement range. The result output still carries the low 32 bits of the sum or difference.
- R2: Non-trapping forms ADDU (1), SUBU (3) and ADDIU (5) give the sum or difference modulo 2^32 and never assert ovf_trap. No logical, shift, compare or LUI code asserts ovf_trap either.
- R3: The 16-bit immediate is used in place of src_b. It is sign-extended for ADDI (4), ADDIU (5), SLTI (21) and SLTIU (22). It is zero-extended for ANDI (10), ORI (11) and XORI (12).
- R4: AND (6), OR (7), XOR (8) and NOR (9) combine src_a and src_b bitwise. NOR gives the complement of the OR.
- R5: SLT (19) and SLTI (21) return 1 when src_a is less than the second operand as two's complement, and 0 otherwise. SLTU (20) and SLTIU (22) make the same comparison as natural numbers. All other result bits are zero.
- R6: The constant shifts SLL (13), SRL (14) and SRA (15) shift src_b by the shamt field. SLL and SRL fill vacated bits with zeros. SRA fills them with copies of bit 31 of src_b.
- R7: The variable shifts SLLV (16), SRLV (17) and SRAV (18) shift src_b by the value in bits 4:0 of src_a. Bits 31:5 of src_a and the shamt field have no effect.
- R8: For every defined code (0 to 23), wr_en is the complement of ovf_trap.
- R9: LUI (23) returns the immediate in bits 31:16 with zeros in bits 15:0.
- R10: Codes 24 to 31 return a zero result, with ovf_trap low and wr_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 5 | Operation select, codes as listed in the requirements |
| src_a | input | 32 | First register operand; also holds the variable shift amount |
| src_b | input | 32 | Second register operand; the value that gets shifted |
| imm | input | 16 | Instruction immediate field |
| shamt | input | 5 | Instruction constant shift field |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow of a trapping add or subtract |
| wr_en | output | 1 | Destination register write enable |

## Verification
The hardest case to reach from the ports is the overflow boundary. A trapping add or subtract sits exactly one step past the most positive or the most negative value, and ADDI adds a negative immediate to the most negative operand. Uniform random operands land there almost never. The stimulus therefore applies these edges directly, and the random phase draws its operands from a pool weighted toward 0, 1, the two signed extremes and all-ones. That pool also probes the set-less-than sign edges, and the random phase sets the upper bits of src_a while a variable shift runs.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int OP_W   = 5;
    localparam int SH_W   = $clog2(DATA_W);

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
        OP_ADDI  = 5'd4,  OP_ADDIU = 5'd5,  OP_AND   = 5'd6,  OP_OR    = 5'd7,
        OP_XOR   = 5'd8,  OP_NOR   = 5'd9,  OP_ANDI  = 5'd10, OP_ORI   = 5'd11,
        OP_XORI  = 5'd12, OP_SLL   = 5'd13, OP_SRL   = 5'd14, OP_SRA   = 5'd15,
        OP_SLLV  = 5'd16, OP_SRLV  = 5'd17, OP_SRAV  = 5'd18, OP_SLT   = 5'd19,
        OP_SLTU  = 5'd20, OP_SLTI  = 5'd21, OP_SLTIU = 5'd22, OP_LUI   = 5'd23
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_ARITH, CL_LOGIC, CL_SHIFT, CL_SLT, CL_LUI, CL_NONE
    } alu_class_e;

    typedef enum logic [1:0] {
        LF_AND, LF_OR, LF_XOR, LF_NOR
    } logic_fn_e;

    typedef struct packed {
        alu_class_e cls;
        logic       use_imm;
        logic       imm_sext;
        logic       sub;
        logic       trap;
        logic_fn_e  lfn;
        logic       sh_var;
        logic       sh_left;
        logic       sh_arith;
        logic       slt_uns;
    } alu_ctrl_t;

    function automatic logic [DATA_W-1:0] ext_imm(input logic [IMM_W-1:0] v,
                                                  input logic sext);
        return {{(DATA_W-IMM_W){sext & v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output alu_ctrl_t       ctrl
);
    always_comb begin
        ctrl     = '0;
        ctrl.cls = CL_NONE;
        case (op_code)
            OP_ADD:   begin ctrl.cls = CL_ARITH; ctrl.trap = 1'b1; end
            OP_ADDU:  ctrl.cls = CL_ARITH;
            OP_SUB:   begin ctrl.cls = CL_ARITH; ctrl.sub = 1'b1; ctrl.trap = 1'b1; end
            OP_SUBU:  begin ctrl.cls = CL_ARITH; ctrl.sub = 1'b1; end
            OP_ADDI:  begin ctrl.cls = CL_ARITH; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1;
                            ctrl.trap = 1'b1; end
            OP_ADDIU: begin ctrl.cls = CL_ARITH; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; end
            OP_AND:   begin ctrl.cls = CL_LOGIC; ctrl.lfn = LF_AND; end
            OP_OR:    begin ctrl.cls = CL_LOGIC; ctrl.lfn = LF_OR;  end
            OP_XOR:   begin ctrl.cls = CL_LOGIC; ctrl.lfn = LF_XOR; end
            OP_NOR:   begin ctrl.cls = CL_LOGIC; ctrl.lfn = LF_NOR; end
            OP_ANDI:  begin ctrl.cls = CL_LOGIC; ctrl.lfn = LF_AND; ctrl.use_imm = 1'b1; end
            OP_ORI:   begin ctrl.cls = CL_LOGIC; ctrl.lfn = LF_OR;  ctrl.use_imm = 1'b1; end
            OP_XORI:  begin ctrl.cls = CL_LOGIC; ctrl.lfn = LF_XOR; ctrl.use_imm = 1'b1; end
            OP_SLL:   begin ctrl.cls = CL_SHIFT; ctrl.sh_left = 1'b1; end
            OP_SRL:   ctrl.cls = CL_SHIFT;
            OP_SRA:   begin ctrl.cls = CL_SHIFT; ctrl.sh_arith = 1'b1; end
            OP_SLLV:  begin ctrl.cls = CL_SHIFT; ctrl.sh_var = 1'b1; ctrl.sh_left = 1'b1; end
            OP_SRLV:  begin ctrl.cls = CL_SHIFT; ctrl.sh_var = 1'b1; end
            OP_SRAV:  begin ctrl.cls = CL_SHIFT; ctrl.sh_var = 1'b1; ctrl.sh_arith = 1'b1; end
            OP_SLT:   begin ctrl.cls = CL_SLT; ctrl.sub = 1'b1; end
            OP_SLTU:  begin ctrl.cls = CL_SLT; ctrl.sub = 1'b1; ctrl.slt_uns = 1'b1; end
            OP_SLTI:  begin ctrl.cls = CL_SLT; ctrl.sub = 1'b1; ctrl.use_imm = 1'b1;
                            ctrl.imm_sext = 1'b1; end
            OP_SLTIU: begin ctrl.cls = CL_SLT; ctrl.sub = 1'b1; ctrl.use_imm = 1'b1;
                            ctrl.imm_sext = 1'b1; ctrl.slt_uns = 1'b1; end
            OP_LUI:   ctrl.cls = CL_LUI;
            default:  ctrl.cls = CL_NONE;
        endcase
    end
endmodule

// File: rtl/alu_operand.sv
module alu_operand
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [SH_W-1:0]   shamt,
    input  logic [SH_W-1:0]   reg_amt,
    input  logic              use_imm,
    input  logic              imm_sext,
    input  logic              sh_var,
    output logic [DATA_W-1:0] opnd_b,
    output logic [SH_W-1:0]   sh_amt
);
    logic [DATA_W-1:0] imm_full;

    always_comb begin
        imm_full = ext_imm(imm, imm_sext);
        opnd_b   = use_imm ? imm_full : src_b;
        sh_amt   = sh_var ? reg_amt : shamt;
    end

    always_comb begin
        if (use_imm && !imm_sext)
            AST_ZERO_EXT_HIGH: assert (opnd_b[DATA_W-1:IMM_W] == '0); // R3
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_raw,
    output logic              lt_s,
    output logic              lt_u
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    always_comb begin
        b_eff   = sub ? ~b : b;
        wide    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        sum     = wide[MSB:0];
        ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        lt_s    = sum[MSB] ^ ovf_raw;
        lt_u    = ~wide[DATA_W];
    end

    always_comb begin
        if (sub && (a == b))
            AST_EQUAL_NOT_LESS: assert (!lt_s && !lt_u && sum == '0); // R5
        if (!sub && (a[MSB] != b[MSB]))
            AST_MIXED_SIGN_NO_OVF: assert (!ovf_raw); // R1
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    input  logic [SH_W-1:0]   amt,
    input  logic              left,
    input  logic              arith,
    output logic [DATA_W-1:0] out
);
    logic              fill;
    logic [DATA_W-1:0] stage [SH_W+1];

    assign fill     = arith & ~left & val[DATA_W-1];
    assign stage[0] = left ? bit_rev(val) : val;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]} : stage[k];
    end

    assign out = left ? bit_rev(stage[SH_W]) : stage[SH_W];

    always_comb begin
        if (arith && !left)
            AST_SRA_SIGN_KEPT: assert (out[DATA_W-1] == val[DATA_W-1]); // R6
        if (amt == '0)
            AST_ZERO_SHIFT_IDENT: assert (out == val); // R6
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
(
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] result,
    output logic              ovf_trap,
    output logic              wr_en
);
    alu_ctrl_t         ctrl;
    logic [DATA_W-1:0] opnd_b;
    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] sum;
    logic              ovf_raw;
    logic              lt_s;
    logic              lt_u;
    logic [DATA_W-1:0] sh_out;
    logic [DATA_W-1:0] lg_out;

    alu_decode u_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    alu_operand u_opnd (
        .src_b    (src_b),
        .imm      (imm),
        .shamt    (shamt),
        .reg_amt  (src_a[SH_W-1:0]),
        .use_imm  (ctrl.use_imm),
        .imm_sext (ctrl.imm_sext),
        .sh_var   (ctrl.sh_var),
        .opnd_b   (opnd_b),
        .sh_amt   (sh_amt)
    );

    alu_addsub u_as (
        .a       (src_a),
        .b       (opnd_b),
        .sub     (ctrl.sub),
        .sum     (sum),
        .ovf_raw (ovf_raw),
        .lt_s    (lt_s),
        .lt_u    (lt_u)
    );

    alu_shift u_sh (
        .val   (src_b),
        .amt   (sh_amt),
        .left  (ctrl.sh_left),
        .arith (ctrl.sh_arith),
        .out   (sh_out)
    );

    always_comb begin
        case (ctrl.lfn)
            LF_AND:  lg_out = src_a & opnd_b;
            LF_OR:   lg_out = src_a | opnd_b;
            LF_XOR:  lg_out = src_a ^ opnd_b;
            default: lg_out = ~(src_a | opnd_b);
        endcase
    end

    always_comb begin
        case (ctrl.cls)
            CL_ARITH: result = sum;
            CL_LOGIC: result = lg_out;
            CL_SHIFT: result = sh_out;
            CL_SLT:   result = {{(DATA_W-1){1'b0}}, ctrl.slt_uns ? lt_u : lt_s};
            CL_LUI:   result = {imm, {(DATA_W-IMM_W){1'b0}}};
            default:  result = '0;
        endcase
        ovf_trap = ctrl.trap & ovf_raw;
        wr_en    = (ctrl.cls != CL_NONE) & ~ovf_trap;
    end

    always_comb begin
        if (ovf_trap)
            AST_TRAP_BLOCKS_WRITE: assert (!wr_en); // R8
        if (!ctrl.trap)
            AST_NO_OVERFLOW: assert (!ovf_trap); // R2
        if (ctrl.cls == CL_SLT)
            AST_SLT_BINARY: assert (result[DATA_W-1:1] == '0); // R5
        if (ctrl.cls == CL_LUI)
            AST_LUI_LOW_ZERO: assert (result[DATA_W-IMM_W-1:0] == '0); // R9
        if (ctrl.cls == CL_NONE)
            AST_UNDEF_SILENT: assert (result == '0 && !wr_en && !ovf_trap); // R10
    end
endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic [4:0]  op_code = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf_trap;
    logic        wr_en;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  armed = 1'b0;
    bit  done  = 1'b0;
    int  cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_core dut (
        .op_code (op_code),
        .src_a   (src_a),
        .src_b   (src_b),
        .imm     (imm),
        .shamt   (shamt),
        .result  (result),
        .ovf_trap(ovf_trap),
        .wr_en   (wr_en)
    );

    task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh,
                         output logic [31:0] r, output logic ov, output logic we,
                         output string tag);
        longint sa, sb, si, s;
        logic [31:0] zi, sx;
        bit valid;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        si = longint'($signed(im));
        zi = {16'h0000, im};
        sx = 32'(si);
        r = '0; ov = 1'b0; valid = 1'b1; s = 0;
        case (op)
            5'd0:  begin s = sa + sb; tag = "R1"; end
            5'd1:  begin r = a + b; tag = "R2"; end
            5'd2:  begin s = sa - sb; tag = "R1"; end
            5'd3:  begin r = a - b; tag = "R2"; end
            5'd4:  begin s = sa + si; tag = "R1"; end
            5'd5:  begin r = a + sx; tag = "R3"; end
            5'd6:  begin r = a & b; tag = "R4"; end
            5'd7:  begin r = a | b; tag = "R4"; end
            5'd8:  begin r = a ^ b; tag = "R4"; end
            5'd9:  begin r = ~(a | b); tag = "R4"; end
            5'd10: begin r = a & zi; tag = "R3"; end
            5'd11: begin r = a | zi; tag = "R3"; end
            5'd12: begin r = a ^ zi; tag = "R3"; end
            5'd13: begin r = b << sh; tag = "R6"; end
            5'd14: begin r = b >> sh; tag = "R6"; end
            5'd15: begin r = 32'($signed(b) >>> sh); tag = "R6"; end
            5'd16: begin r = b << a[4:0]; tag = "R7"; end
            5'd17: begin r = b >> a[4:0]; tag = "R7"; end
            5'd18: begin r = 32'($signed(b) >>> a[4:0]); tag = "R7"; end
            5'd19: begin r = {31'd0, sa < sb}; tag = "R5"; end
            5'd20: begin r = {31'd0, a < b}; tag = "R5"; end
            5'd21: begin r = {31'd0, sa < si}; tag = "R5"; end
            5'd22: begin r = {31'd0, a < sx}; tag = "R5"; end
            5'd23: begin r = {im, 16'h0000}; tag = "R9"; end
            default: begin valid = 1'b0; tag = "R10"; end
        endcase
        if (op == 5'd0 || op == 5'd2 || op == 5'd4) begin
            r  = 32'(s);
            ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end
        we = valid && !ov;
    endtask

    always @(negedge clk) begin
        logic [31:0] er;
        logic eo, ew;
        string tg;
        if (armed && !done) begin
            model(op_code, src_a, src_b, imm, shamt, er, eo, ew, tg);
            n_cmp++;
            if (result !== er) begin
                n_bad++;
                $display("FAIL %s result op=%0d a=%h b=%h imm=%h sh=%0d actual=%h expected=%h",
                         tg, op_code, src_a, src_b, imm, shamt, result, er);
            end else if (ovf_trap !== eo) begin
                n_bad++;
                $display("FAIL %s ovf_trap op=%0d a=%h b=%h actual=%b expected=%b",
                         (op_code == 5'd0 || op_code == 5'd2 || op_code == 5'd4) ? "R1" : "R2",
                         op_code, src_a, src_b, ovf_trap, eo);
            end else if (wr_en !== ew) begin
                n_bad++;
                $display("FAIL %s wr_en op=%0d a=%h b=%h actual=%b expected=%b",
                         (op_code > 5'd23) ? "R10" : "R8", op_code, src_a, src_b, wr_en, ew);
            end
        end
    end

    task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh);
        @(posedge clk);
        op_code = op; src_a = a; src_b = b; imm = im; shamt = sh;
        armed = 1'b1;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            default: return $urandom();
        endcase
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: overflow edges on the trapping forms
        apply(5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
        apply(5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 5'd0);
        apply(5'd0, 32'h7FFF_FFFE, 32'h0000_0001, 16'h0, 5'd0);
        apply(5'd2, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0);
        apply(5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0);
        apply(5'd2, 32'h0000_0000, 32'h8000_0000, 16'h0, 5'd0);
        apply(5'd4, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
        apply(5'd4, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0);
        apply(5'd4, 32'h7FFF_FFFF, 32'h0, 16'hFFFF, 5'd0);
        // R2: same edges on the non-trapping forms
        apply(5'd1, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
        apply(5'd3, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0);
        apply(5'd5, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
        // R3: immediate extension
        apply(5'd5, 32'h0000_0010, 32'h0, 16'h8000, 5'd0);
        apply(5'd10, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0);
        apply(5'd11, 32'h0000_0000, 32'h0, 16'hF00F, 5'd0);
        apply(5'd12, 32'hFFFF_0000, 32'h0, 16'hFFFF, 5'd0);
        // R4: bitwise
        apply(5'd6, 32'hF0F0_1234, 32'h0FF0_FFFF, 16'h0, 5'd0);
        apply(5'd9, 32'h0000_0000, 32'h0000_0000, 16'h0, 5'd0);
        apply(5'd9, 32'hA5A5_0000, 32'h0000_5A5A, 16'h0, 5'd0);
        // R5: compares across the sign edge
        apply(5'd19, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0);
        apply(5'd20, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0);
        apply(5'd19, 32'h0000_0005, 32'h0000_0005, 16'h0, 5'd0);
        apply(5'd21, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0);
        apply(5'd22, 32'h0000_0001, 32'h0, 16'hFFFF, 5'd0);
        // R6: constant shifts, sign fill
        apply(5'd15, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
        apply(5'd14, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
        apply(5'd13, 32'h0, 32'h0000_0001, 16'h0, 5'd31);
        apply(5'd15, 32'h0, 32'h4000_0000, 16'h0, 5'd4);
        // R7: variable shifts ignore upper src_a bits and shamt
        apply(5'd16, 32'hFFFF_FFE3, 32'h0000_0001, 16'h0, 5'd7);
        apply(5'd18, 32'h1234_5668, 32'h8765_4321, 16'h0, 5'd1);
        apply(5'd17, 32'h0000_0020, 32'hDEAD_BEEF, 16'h0, 5'd9);
        // R9: load upper
        apply(5'd23, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF, 5'd3);
        // R10: undefined codes
        apply(5'd24, 32'h7FFF_FFFF, 32'h0000_0001, 16'hFFFF, 5'd1);
        apply(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31);
        // R8 and all: random sweep
        for (int i = 0; i < 4000; i++)
            apply(5'($urandom_range(0, 31)), pick(), pick(), 16'($urandom()),
                  5'($urandom_range(0, 31)));
        @(posedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule